// File: doc/BRIEF.md
# Digital potentiometer command controller

This block holds the register state of a 10-bit digitally controlled potentiometer and decodes the host commands that act on it. A serial front end delivers received bytes one per `rx_valid` strobe while the chip-select level `cs_active` is high. The block hands back the byte to shift out next on `tx_byte`. Each frame opens with an identification byte that must carry the device type nibble and the value of the address strap. An instruction byte follows, naming the operation and one of four data registers.

The state is a volatile wiper register, four emulated nonvolatile data registers and a write-in-progress flag. The wiper drives a 10-bit position output and a 1024-line one-hot tap select for the resistor switches. Two transfer commands move a value between a data register and the wiper and need only the two header bytes. Reads and writes of the wiper, the data registers and the status flag use a four-byte frame. Any change to a data register counts as a nonvolatile write. Such a write raises the busy flag for a programmable number of clock cycles. It is refused while the write-protect input is low or while an earlier write is still busy.

Top module: `dpot_cmd_ctrl`

## Requirements
- R1: A frame is acted on only if its first byte has bits [7:4] equal to 0101b and bit 1 equal to `addr_strap`. Bits [3:2] are don't-care. On a mismatch the block ignores every further byte until `cs_active` falls: no register changes and `tx_byte` stays 00h.
- R2: Bit 0 of the first byte is the direction bit: 1 for read commands, 0 for all others. If the bit disagrees with the opcode, the frame is ignored. The reserved opcode 011b is always ignored.
- R3: The second byte holds the opcode in bits [7:5] and the register pointer in bits [1:0]; bits [4:2] are don't-care. The opcodes are: 000 read status, 001 wiper to data register, 010 data register to wiper, 100 read wiper, 101 write wiper, 110 read data register, 111 write data register.
- R4: In a write-wiper frame, the wiper takes the value {byte3[1:0], byte4}, and bits [7:2] of byte 3 are ignored. Bytes after the last byte of a command's frame are ignored. This includes bytes that follow a two-byte transfer.
- R5: In a read frame, `tx_byte` becomes {6'b0, value[9:8]} after the second byte is accepted and value[7:0] after the third byte is accepted. A status read returns value = {9'b0, busy}, with busy taken as it stood when the third byte arrived. `tx_byte` is 00h whenever `cs_active` is low.
- R6: A data-register-to-wiper transfer loads the wiper from the selected data register once the second byte is accepted.
- R7: A nonvolatile write (wiper to data register, or write data register) updates the selected register. `wip` is then high for exactly BUSY_CYCLES clock cycles, starting the cycle after the accepting byte.
- R8: A nonvolatile write is suppressed, leaving the data register unchanged, while `wp_n` is low. It is also suppressed while `wip` is high. A write refused for `wp_n` does not raise `wip`.
- R9: `tap_sel` has exactly one bit set, at the index equal to `wiper` (000h selects line 0, 3FFh selects line 1023).
- R10: After reset, `wiper` equals the reset value of data register 0, `wip` is 0 and `tx_byte` is 00h.
- R11: If `cs_active` falls before a four-byte frame completes, the frame has no effect, and the next frame starts again at its identification byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Frame select level from the serial front end |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| addr_strap | input | 1 | Device address strap compared with bit 1 of the first byte |
| wp_n | input | 1 | Write protect, active low, blocks data register writes |
| tx_byte | output | 8 | Byte to be shifted out next |
| wiper | output | 10 | Current wiper position |
| tap_sel | output | 1024 | One-hot tap switch enables |
| wip | output | 1 | Nonvolatile write busy flag |

## Verification
The assertions take some things for granted about the inputs. `cs_active` drops between frames. `rx_valid` is only strobed while selected. `rst_n` is low from time zero until the first clock edges. The stimulus meets these conditions by building every frame in one task that raises the select, strobes each byte with an idle cycle between strobes, and then lowers the select again. `wp_n` is changed only between frames, so the bench knows which protect level each write saw. The bench samples `wip` just before the byte that commits a write or a status read, and uses that sample to predict refusals during busy periods.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 10;
  localparam int NUM_DR  = 4;
  localparam int PTR_W   = $clog2(NUM_DR);
  localparam int NUM_TAP = 1 << DATA_W;
  localparam logic [3:0] ID_NIBBLE = 4'b0101;

  typedef enum logic [2:0] {
    OP_RD_STAT = 3'b000,
    OP_W2D     = 3'b001,
    OP_D2W     = 3'b010,
    OP_RSVD    = 3'b011,
    OP_RD_WIP  = 3'b100,
    OP_WR_WIP  = 3'b101,
    OP_RD_DR   = 3'b110,
    OP_WR_DR   = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_XFER, EV_WRITE, EV_RD_HI, EV_RD_LO
  } ev_e;

  typedef struct packed {
    ev_e               ev;
    op_e               op;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic id_match(logic [BYTE_W-1:0] b, logic a0);
    return (b[7:4] == ID_NIBBLE) && (b[1] == a0);
  endfunction

  function automatic logic op_is_read(op_e op);
    return (op == OP_RD_STAT) || (op == OP_RD_WIP) || (op == OP_RD_DR);
  endfunction

  function automatic logic op_is_xfer(op_e op);
    return (op == OP_W2D) || (op == OP_D2W);
  endfunction

  function automatic logic instr_legal(op_e op, logic rw);
    return (op != OP_RSVD) && (rw == op_is_read(op));
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(logic [DATA_W-1:0] v);
    return BYTE_W'(v >> BYTE_W);
  endfunction

  function automatic logic [BYTE_W-1:0] lo_byte(logic [DATA_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dpot_frame_parser.sv
module dpot_frame_parser
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              strap_a0,
  output cmd_t              cmd,
  output logic              reject
);
  logic [1:0]             idx_q;
  logic                   dead_q;
  logic                   rw_q;
  op_e                    op_q;
  logic [PTR_W-1:0]       ptr_q;
  logic [DATA_W-BYTE_W-1:0] hi_q;

  op_e              op_in;
  logic [PTR_W-1:0] ptr_in;
  logic             take;

  assign op_in  = op_e'(rx_data[7:5]);
  assign ptr_in = rx_data[PTR_W-1:0];
  assign take   = sel && rx_valid && !dead_q;

  always_comb begin
    cmd    = '0;
    reject = 1'b0;
    if (take) begin
      case (idx_q)
        2'd0: reject = !id_match(rx_data, strap_a0);
        2'd1: begin
          if (!instr_legal(op_in, rw_q)) begin
            reject = 1'b1;
          end else if (op_is_xfer(op_in)) begin
            cmd.ev  = EV_XFER;
            cmd.op  = op_in;
            cmd.ptr = ptr_in;
          end else if (op_is_read(op_in)) begin
            cmd.ev  = EV_RD_HI;
            cmd.op  = op_in;
            cmd.ptr = ptr_in;
          end
        end
        2'd2: begin
          if (op_is_read(op_q)) begin
            cmd.ev  = EV_RD_LO;
            cmd.op  = op_q;
            cmd.ptr = ptr_q;
          end
        end
        default: begin
          if (!op_is_read(op_q)) begin
            cmd.ev   = EV_WRITE;
            cmd.op   = op_q;
            cmd.ptr  = ptr_q;
            cmd.data = {hi_q, rx_data};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dead_q <= 1'b0;
      rw_q   <= 1'b0;
      op_q   <= OP_RD_STAT;
      ptr_q  <= '0;
      hi_q   <= '0;
    end else if (!sel) begin
      idx_q  <= '0;
      dead_q <= 1'b0;
    end else if (take) begin
      if (reject) begin
        dead_q <= 1'b1;
      end else begin
        case (idx_q)
          2'd0: rw_q <= rx_data[0];
          2'd1: begin
            op_q  <= op_in;
            ptr_q <= ptr_in;
          end
          2'd2: hi_q <= rx_data[DATA_W-BYTE_W-1:0];
          default: ;
        endcase
        if ((idx_q == 2'd3) || (idx_q == 2'd1 && op_is_xfer(op_in)))
          dead_q <= 1'b1;
        else
          idx_q <= idx_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/dpot_busy_timer.sv
module dpot_busy_timer #(
  parameter int CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dpot_reg_bank.sv
module dpot_reg_bank
  import dpot_pkg::*;
#(
  parameter int                         BUSY_CYCLES = 2500000,
  parameter logic [NUM_DR*DATA_W-1:0]   DR_INIT     = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cmd_t                     cmd,
  input  logic                     wp_n,
  output logic [DATA_W-1:0]        wiper,
  output logic [NUM_DR*DATA_W-1:0] dr_flat,
  output logic                     wip,
  output logic                     nv_req,
  output logic                     nv_accept,
  output logic                     wiper_we
);
  logic [DATA_W-1:0] dr_q [NUM_DR];
  logic [DATA_W-1:0] nv_data;
  logic [DATA_W-1:0] wiper_d;

  assign nv_req = ((cmd.ev == EV_XFER)  && (cmd.op == OP_W2D)) ||
                  ((cmd.ev == EV_WRITE) && (cmd.op == OP_WR_DR));
  assign nv_accept = nv_req && wp_n && !wip;
  assign nv_data   = (cmd.op == OP_W2D) ? wiper : cmd.data;

  assign wiper_we = ((cmd.ev == EV_XFER)  && (cmd.op == OP_D2W)) ||
                    ((cmd.ev == EV_WRITE) && (cmd.op == OP_WR_WIP));
  assign wiper_d  = (cmd.op == OP_D2W) ? dr_q[cmd.ptr] : cmd.data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper <= DR_INIT[DATA_W-1:0];
    end else if (wiper_we) begin
      wiper <= wiper_d;
    end
  end

  for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
    always_ff @(posedge clk) begin
      if (!rst_n)
        dr_q[g] <= DR_INIT[g*DATA_W +: DATA_W];
      else if (nv_accept && (cmd.ptr == PTR_W'(g)))
        dr_q[g] <= nv_data;
    end
    assign dr_flat[g*DATA_W +: DATA_W] = dr_q[g];
  end

  dpot_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (nv_accept),
    .busy  (wip)
  );
endmodule

// File: rtl/dpot_tap_decoder.sv
module dpot_tap_decoder
  import dpot_pkg::*;
(
  input  logic [DATA_W-1:0]  pos,
  output logic [NUM_TAP-1:0] taps
);
  for (genvar t = 0; t < NUM_TAP; t++) begin : g_tap
    assign taps[t] = (pos == DATA_W'(t));
  end
endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl
  import dpot_pkg::*;
#(
  parameter int                       BUSY_CYCLES = 2500000,
  parameter logic [NUM_DR*DATA_W-1:0] DR_INIT     = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_active,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               addr_strap,
  input  logic               wp_n,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic [DATA_W-1:0]  wiper,
  output logic [NUM_TAP-1:0] tap_sel,
  output logic               wip
);
  cmd_t                     cmd;
  logic                     frame_reject;
  logic [NUM_DR*DATA_W-1:0] dr_flat;
  logic                     nv_req;
  logic                     nv_accept;
  logic                     wiper_we;
  logic [DATA_W-1:0]        rd_value;

  dpot_frame_parser u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (cs_active),
    .rx_valid (rx_valid),
    .rx_data  (rx_byte),
    .strap_a0 (addr_strap),
    .cmd      (cmd),
    .reject   (frame_reject)
  );

  dpot_reg_bank #(.BUSY_CYCLES(BUSY_CYCLES), .DR_INIT(DR_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .wp_n      (wp_n),
    .wiper     (wiper),
    .dr_flat   (dr_flat),
    .wip       (wip),
    .nv_req    (nv_req),
    .nv_accept (nv_accept),
    .wiper_we  (wiper_we)
  );

  dpot_tap_decoder u_taps (
    .pos  (wiper),
    .taps (tap_sel)
  );

  always_comb begin
    case (cmd.op)
      OP_RD_WIP: rd_value = wiper;
      OP_RD_DR:  rd_value = dr_flat[cmd.ptr*DATA_W +: DATA_W];
      default:   rd_value = {{(DATA_W-1){1'b0}}, wip};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_active) begin
      tx_byte <= '0;
    end else if (cmd.ev == EV_RD_HI) begin
      tx_byte <= hi_byte(rd_value);
    end else if (cmd.ev == EV_RD_LO) begin
      tx_byte <= lo_byte(rd_value);
    end
  end
endmodule

// File: rtl/dpot_cmd_checker.sv
module dpot_cmd_checker
  import dpot_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wp_n,
  input logic                     wip,
  input logic [DATA_W-1:0]        wiper,
  input logic [NUM_TAP-1:0]       tap_sel,
  input logic                     nv_req,
  input logic                     nv_accept,
  input logic                     wiper_we,
  input logic [NUM_DR*DATA_W-1:0] dr_flat
);
  AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1); // R9
  AST_TAP_AT_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper]); // R9
  AST_PROTECT_HOLDS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && !wp_n) |=> $stable(dr_flat)); // R8
  AST_BUSY_HOLDS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && wip) |=> $stable(dr_flat)); // R8
  AST_WRITE_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    nv_accept |=> wip); // R7
  AST_WIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(nv_accept)); // R7
  AST_DR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dr_flat) |-> $past(nv_accept)); // R7
  AST_WIPER_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(wiper_we)); // R6
endmodule

bind dpot_cmd_ctrl dpot_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .wip       (wip),
  .wiper     (wiper),
  .tap_sel   (tap_sel),
  .nv_req    (nv_req),
  .nv_accept (nv_accept),
  .wiper_we  (wiper_we),
  .dr_flat   (dr_flat)
);

// File: tb/tb_dpot_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_cmd_ctrl;
  localparam int BUSY = 24;
  localparam logic [39:0] INIT = {10'h0C3, 10'h2A5, 10'h3FF, 10'h1E0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_active = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic addr_strap = 1'b1;
  logic wp_n = 1'b1;
  logic [7:0] tx_byte;
  logic [9:0] wiper;
  logic [1023:0] tap_sel;
  logic wip;

  always #2 clk = ~clk;

  dpot_cmd_ctrl #(.BUSY_CYCLES(BUSY), .DR_INIT(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .addr_strap(addr_strap), .wp_n(wp_n),
    .tx_byte(tx_byte), .wiper(wiper), .tap_sel(tap_sel), .wip(wip)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0] m_wiper;
  logic [9:0] m_dr [4];
  logic [7:0] fb [6];
  logic [7:0] cap_hi, cap_lo;
  logic [5:0] cap_wip;

  int busy_run = 0;
  int last_busy_len = 0;
  always @(negedge clk) begin
    if (wip) busy_run <= busy_run + 1;
    else if (busy_run != 0) begin
      last_busy_len <= busy_run;
      busy_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_b(logic a0, logic rw, logic [1:0] dc);
    return {4'b0101, dc, a0, rw};
  endfunction

  function automatic logic [7:0] ins_b(logic [2:0] op, logic [1:0] ptr, logic [2:0] dc);
    return {op, dc, ptr};
  endfunction

  function automatic bit is_rd(logic [2:0] op);
    return (op == 3'b000) || (op == 3'b100) || (op == 3'b110);
  endfunction

  task automatic run_frame(input int n);
    @(negedge clk) cs_active = 1'b1;
    cap_hi = 8'h00; cap_lo = 8'h00; cap_wip = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = fb[i]; cap_wip[i] = wip;
      @(negedge clk);
      rx_valid = 1'b0;
      if (i == 1) cap_hi = tx_byte;
      if (i == 2) cap_lo = tx_byte;
    end
    @(negedge clk) cs_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    chk(wiper == m_wiper, req, wiper, m_wiper);
    chk(tap_sel == (1024'd1 << m_wiper), "R9", tap_sel[31:0], m_wiper); // R9
  endtask

  task automatic model_and_check(input int n);
    logic [2:0] op; logic [1:0] ptr; logic [9:0] v; bit ok;
    op = fb[1][7:5]; ptr = fb[1][1:0];
    ok = (n >= 2) && (fb[0][7:4] == 4'b0101) && (fb[0][1] == addr_strap) &&
         (op != 3'b011) && (fb[0][0] == is_rd(op));
    if (!ok) begin
      if (n >= 3) begin
        chk(cap_hi == 8'h00, "R1 R2 reject hi", cap_hi, 0);
        chk(cap_lo == 8'h00, "R1 R2 reject lo", cap_lo, 0);
      end
    end else begin
      case (op)
        3'b001: if (wp_n && !cap_wip[1]) m_dr[ptr] = m_wiper;
        3'b010: m_wiper = m_dr[ptr];
        3'b101: if (n >= 4) m_wiper = {fb[2][1:0], fb[3]};
        3'b111: if (n >= 4 && wp_n && !cap_wip[3]) m_dr[ptr] = {fb[2][1:0], fb[3]};
        default: begin
          v = (op == 3'b100) ? m_wiper : (op == 3'b110) ? m_dr[ptr] : {9'b0, cap_wip[2]};
          chk(cap_hi == {6'b0, v[9:8]}, "R5 hi", cap_hi, v[9:8]);
          if (n >= 3) chk(cap_lo == v[7:0], "R5 lo", cap_lo, v[7:0]);
        end
      endcase
    end
    check_outputs("R3 R4 R6 R11 wiper");
  endtask

  task automatic read_dr(input logic [1:0] ptr, input string req);
    fb[0] = id_b(addr_strap, 1'b1, 2'b00); fb[1] = ins_b(3'b110, ptr, 3'b000);
    fb[2] = 8'h00; fb[3] = 8'h00;
    run_frame(4);
    chk({cap_hi[1:0], cap_lo} == m_dr[ptr], req, {cap_hi[1:0], cap_lo}, m_dr[ptr]);
  endtask

  task automatic wait_idle();
    while (wip) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] op; int n; int r;
    void'($urandom(32'h5EED1234));
    m_dr[0] = 10'h1E0; m_dr[1] = 10'h3FF; m_dr[2] = 10'h2A5; m_dr[3] = 10'h0C3;
    m_wiper = m_dr[0];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(wiper == 10'h1E0, "R10 wiper", wiper, 10'h1E0);
    chk(wip == 1'b0, "R10 wip", wip, 0);
    chk(tx_byte == 8'h00, "R10 tx", tx_byte, 0);
    check_outputs("R10");

    // R4 write wiper, top bits of byte3 ignored, extra bytes ignored
    fb[0] = id_b(1'b1, 1'b0, 2'b11); fb[1] = ins_b(3'b101, 2'd2, 3'b101);
    fb[2] = 8'hFE; fb[3] = 8'h5A; fb[4] = 8'h01; fb[5] = 8'hFF;
    run_frame(6); model_and_check(6);
    chk(wiper == 10'h25A, "R4 write wiper", wiper, 10'h25A);

    // R9 extremes
    fb[2] = 8'h00; fb[3] = 8'h00; run_frame(4); model_and_check(4);
    chk(tap_sel[0] == 1'b1, "R9 low end", tap_sel[0], 1);
    fb[2] = 8'h03; fb[3] = 8'hFF; run_frame(4); model_and_check(4);
    chk(tap_sel[1023] == 1'b1, "R9 high end", tap_sel[1023], 1);

    // R1 wrong strap then wrong nibble
    fb[0] = id_b(1'b0, 1'b0, 2'b00); fb[1] = ins_b(3'b101, 2'd0, 3'b000);
    fb[2] = 8'h01; fb[3] = 8'h11;
    run_frame(4); model_and_check(4);
    chk(wiper == 10'h3FF, "R1 strap mismatch", wiper, 10'h3FF);
    fb[0] = 8'h61; fb[1] = ins_b(3'b110, 2'd1, 3'b000);
    run_frame(4); model_and_check(4);

    // R2 reserved opcode and direction mismatch
    fb[0] = id_b(1'b1, 1'b0, 2'b00); fb[1] = ins_b(3'b011, 2'd0, 3'b000);
    run_frame(4); model_and_check(4);
    fb[0] = id_b(1'b1, 1'b1, 2'b00); fb[1] = ins_b(3'b101, 2'd0, 3'b000);
    run_frame(4); model_and_check(4);
    chk(wiper == 10'h3FF, "R2 dir mismatch", wiper, 10'h3FF);

    // R6 transfer DR2 to wiper, with trailing bytes ignored (R4)
    fb[0] = id_b(1'b1, 1'b0, 2'b00); fb[1] = ins_b(3'b010, 2'd2, 3'b000);
    fb[2] = 8'h01; fb[3] = 8'h23;
    run_frame(4); model_and_check(4);
    chk(wiper == 10'h2A5, "R6 xfer", wiper, 10'h2A5);

    // R7 wiper to DR3, busy length, status while busy and after
    fb[1] = ins_b(3'b001, 2'd3, 3'b000);
    run_frame(2); model_and_check(2);
    fb[0] = id_b(1'b1, 1'b1, 2'b00); fb[1] = ins_b(3'b000, 2'd0, 3'b000);
    fb[2] = 8'h00; fb[3] = 8'h00;
    run_frame(4); model_and_check(4);
    chk(cap_lo == 8'h01, "R5 R7 status busy", cap_lo, 1);
    wait_idle();
    chk(last_busy_len == BUSY, "R7 busy length", last_busy_len, BUSY);
    run_frame(4); model_and_check(4);
    chk(cap_lo == 8'h00, "R5 status idle", cap_lo, 0);
    read_dr(2'd3, "R7 dr3");

    // R8 write-protect
    wp_n = 1'b0;
    fb[0] = id_b(1'b1, 1'b0, 2'b00); fb[1] = ins_b(3'b111, 2'd1, 3'b000);
    fb[2] = 8'h00; fb[3] = 8'h42;
    run_frame(4); model_and_check(4);
    chk(wip == 1'b0, "R8 no busy", wip, 0);
    read_dr(2'd1, "R8 protected");
    wp_n = 1'b1;

    // R8 busy blocks second write
    fb[0] = id_b(1'b1, 1'b0, 2'b00); fb[1] = ins_b(3'b111, 2'd0, 3'b000);
    fb[2] = 8'h02; fb[3] = 8'h77;
    run_frame(4); model_and_check(4);
    fb[3] = 8'h99; run_frame(4); model_and_check(4);
    read_dr(2'd0, "R8 busy block");
    wait_idle();

    // R11 aborted frame then fresh frame
    fb[0] = id_b(1'b1, 1'b0, 2'b00); fb[1] = ins_b(3'b101, 2'd0, 3'b000);
    fb[2] = 8'h01; fb[3] = 8'h10;
    run_frame(3); model_and_check(3);
    chk(wiper == m_wiper, "R11 abort", wiper, m_wiper);
    run_frame(4); model_and_check(4);
    chk(wiper == 10'h110, "R11 next frame", wiper, 10'h110);

    // random mix
    for (int k = 0; k < 300; k++) begin
      op = 3'($urandom_range(0, 7));
      r = $urandom_range(0, 99);
      fb[0] = id_b((r < 5) ? ~addr_strap : addr_strap,
                   (r >= 5 && r < 10) ? ~is_rd(op) : is_rd(op), 2'($urandom));
      if (r >= 95) fb[0][7:4] = 4'($urandom);
      fb[1] = ins_b(op, 2'($urandom), 3'($urandom));
      for (int j = 2; j < 6; j++) fb[j] = 8'($urandom);
      n = (op == 3'b001 || op == 3'b010) ? $urandom_range(2, 4) : $urandom_range(3, 5);
      wp_n = ($urandom_range(0, 9) != 0);
      run_frame(n);
      model_and_check(n);
    end
    wp_n = 1'b1;
    wait_idle();
    for (int p = 0; p < 4; p++) read_dr(2'(p), "R7 R8 final dr");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule